// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

This block holds six independent clock dividers behind two 32-bit configuration words. Each word carries three generators. Each generator picks one of several source clocks and divides it by a programmable ratio. Its output is low while the generator is off. All sources arrive as single-cycle enable ticks in one fabric clock, and every output is a level that changes only on the ticks of its selected source. Software writes a configuration word through a synchronous port and can read either word back at any time.

An elaboration-time parameter chooses between two field layouts.

- **Legacy layout.** Each generator has a one-bit source choice between two sources and its own enable bit. It always divides by an even ratio.
- **Extended layout.** Each generator has a two-bit mux over three sources, where zero means off. One global scale bit switches all six generators from even ratios to any integer ratio from 1 to 256.

A per-generator resume strobe turns an idle generator back on with the source it last used. Ratio and source changes wait for the end of the period that is running, so no phase is ever cut short.

Top module: `freq_gen_bank`

## Requirements
- R1: After reset both configuration words read as zero and all six outputs are low.
- R2: `rd_data` returns the word addressed by `rd_addr`. That word holds the value of the last write to it, changed only by resume strobes.
- R3: Generator g uses the 10-bit field of word g/3 that starts at bit 10*(g mod 3). Field bits [9:2] hold the divider value N.
- R4: In the legacy layout:
  - field bit 0 picks the source (0 = `src_tick[0]`, 1 = `src_tick[1]`);
  - field bit 1 enables the output;
  - the ratio is always 2*(N+1), whatever bit 30 of word 0 holds.
- R5: In the extended layout, field bits [1:0] form a mux. Value 0 turns the generator off, and values 1, 2 and 3 select `src_tick[0]`, `src_tick[1]` and `src_tick[2]`.
- R6: In the extended layout, bit 30 of word 0 is a scale bit for all six generators. When it is clear the ratio is 2*(N+1). When it is set the ratio is N+1.
- R7: For a ratio R of 2 or more, the output is high for floor(R/2) ticks of the selected source and low for the rest. The first high phase begins one clock after the generator is turned on.
- R8: With a ratio of 1, the output equals the selected source tick in every cycle.
- R9: An off generator drives its output low from the cycle its field reads as off, and its count restarts from zero. When it is turned on again it starts with a full high phase.
- R10: A new ratio or source written to a running generator takes effect only when the current period ends.
- R11: A resume strobe writes a value into the generator's field:
  - extended layout: the mux gets the last nonzero selection written to it (1 after reset);
  - legacy layout: the enable bit is set and the source bit is kept.
  
  A write to the same word in the same cycle wins over the strobe.
- R12: Ticks of sources other than the selected one do not advance a generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a configuration word |
| wr_addr | input | 1 | Word being written (0 or 1) |
| wr_data | input | 32 | Value written |
| rd_addr | input | 1 | Word being read |
| rd_data | output | 32 | Contents of the addressed word |
| gen_resume | input | 6 | Per-generator resume strobe |
| src_tick | input | NSRC (3 extended, 2 legacy) | Source clock-enable ticks |
| clk_out | output | 6 | Divided output levels |

## Verification
The divider is driven with three source patterns:
- **Continuous ticks on the selected source.** High-phase and rising-edge counts over whole periods separate even ratios, odd ratios and the scaled and unscaled divide.
- **Ticks on the wrong source only.** This must leave the output frozen, which shows that the mux, and not just any tick, drives the count.
- **Alternating ticks at a ratio of one.** This shows the pass-through path.

A ratio change issued one tick into a long period is traced sample by sample. A truncated period and a correctly deferred one then give different bit patterns. Both layouts run side by side on the same writes, so one word checks the legacy enable, source and scale handling against the extended mux.

// File: rtl/freq_gen_bank.sv
module freq_gen_bank #(
  parameter bit EXT_MODE = 1'b1,
  localparam int NSRC = EXT_MODE ? 3 : 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            rd_addr,
  output logic [31:0]     rd_data,
  input  logic [5:0]      gen_resume,
  input  logic [NSRC-1:0] src_tick,
  output logic [5:0]      clk_out
);
  localparam int NGEN  = 6;
  localparam int PERW  = 3;
  localparam int FW    = 10;
  localparam int RW    = 10;
  localparam int SCALE = 30;

  logic [31:0]     cfg_q [2];
  logic [1:0]      rest_f [NGEN];
  logic [NGEN-1:0] on_v, run_v;
  logic [2:0]      tk;

  assign tk      = 3'(src_tick);
  assign rd_data = cfg_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
    end else begin
      for (int r = 0; r < 2; r++) begin
        if (wr_en && wr_addr == 1'(r)) cfg_q[r] <= wr_data;
        else
          for (int k = 0; k < PERW; k++)
            if (gen_resume[PERW*r+k]) cfg_q[r][FW*k +: 2] <= rest_f[PERW*r+k];
      end
    end
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    localparam int RI = g / PERW;
    localparam int LO = FW * (g % PERW);

    logic [FW-1:0] fld;
    logic          on, run_q, tick_a, wrap;
    logic [1:0]    sel, src_q;
    logic [RW-1:0] n1, ratio, rat_q, cnt_q;

    assign fld = cfg_q[RI][LO +: FW];
    assign n1  = {2'b00, fld[9:2]} + RW'(1);

    if (EXT_MODE) begin : g_ext
      logic [1:0] mem_q;
      always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= 2'd1;
        else if (wr_en && wr_addr == 1'(RI) && wr_data[LO +: 2] != 2'd0)
          mem_q <= wr_data[LO +: 2];
      end
      assign on        = fld[1:0] != 2'd0;
      assign sel       = fld[1:0] - 2'd1;
      assign ratio     = cfg_q[0][SCALE] ? n1 : (n1 << 1);
      assign rest_f[g] = mem_q;
    end else begin : g_leg
      assign on        = fld[1];
      assign sel       = {1'b0, fld[0]};
      assign ratio     = n1 << 1;
      assign rest_f[g] = {1'b1, fld[0]};
    end

    assign tick_a = tk[src_q];
    assign wrap   = cnt_q == rat_q - RW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= 1'b0;
        src_q <= '0;
        rat_q <= RW'(2);
        cnt_q <= '0;
      end else if (!on) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        src_q <= sel;
        rat_q <= ratio;
        cnt_q <= '0;
      end else if (tick_a) begin
        if (wrap) begin
          cnt_q <= '0;
          src_q <= sel;
          rat_q <= ratio;
        end else begin
          cnt_q <= cnt_q + RW'(1);
        end
      end
    end

    assign clk_out[g] = on & run_q & ((rat_q == RW'(1)) ? tick_a : (cnt_q < (rat_q >> 1)));
    assign on_v[g]    = on;
    assign run_v[g]   = run_q;
  end
endmodule

module freq_gen_bank_chk #(
  parameter int NSRC = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_addr,
  input logic [31:0]     wr_data,
  input logic [5:0]      gen_resume,
  input logic [NSRC-1:0] src_tick,
  input logic [31:0]     cfg0,
  input logic [31:0]     cfg1,
  input logic [5:0]      on_v,
  input logic [5:0]      run_v,
  input logic [5:0]      clk_out
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (clk_out == 6'd0 && cfg0 == 32'd0 && cfg1 == 32'd0));

  a_r2_write_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> cfg0 == $past(wr_data));

  a_r2_write_word1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr) |=> cfg1 == $past(wr_data));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && gen_resume == 6'd0) |=> ($stable(cfg0) && $stable(cfg1)));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick == '0 && !wr_en && gen_resume == 6'd0 && run_v == on_v)
      |=> (src_tick != '0 || $stable(clk_out)));

  for (genvar g = 0; g < 6; g++) begin : g_off
    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !on_v[g] |-> !clk_out[g]);
  end
endmodule

bind freq_gen_bank freq_gen_bank_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .gen_resume(gen_resume), .src_tick(src_tick), .cfg0(cfg_q[0]), .cfg1(cfg_q[1]),
  .on_v(on_v), .run_v(run_v), .clk_out(clk_out)
);

// File: tb/freq_gen_bank_bench.sv
module freq_gen_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [5:0]  gen_resume = '0;
  logic [2:0]  src_tick = '0;
  logic [31:0] rd_ext, rd_leg;
  logic [5:0]  out_ext, out_leg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_gen_bank #(.EXT_MODE(1'b1)) u_freq_gen_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_ext), .gen_resume(gen_resume),
    .src_tick(src_tick), .clk_out(out_ext));

  freq_gen_bank #(.EXT_MODE(1'b0)) u_freq_gen_bank_leg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_leg), .gen_resume(gen_resume),
    .src_tick(src_tick[1:0]), .clk_out(out_leg));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_cfg();
    src_tick = '0;
    wr(1'b0, 32'd0);
    wr(1'b1, 32'd0);
    @(negedge clk);
  endtask

  task automatic measure(input bit leg, input int g, input int cyc, output int highs, output int rises);
    int guard;
    bit v, prev;
    guard = 0; prev = 1'b0; highs = 0; rises = 0;
    while (!(leg ? out_leg[g] : out_ext[g]) && guard < 40) begin
      @(negedge clk); guard++;
    end
    for (int i = 0; i < cyc; i++) begin
      v = leg ? out_leg[g] : out_ext[g];
      if (v) highs++;
      if (v && !prev) rises++;
      prev = v;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_readback();
    check(out_ext == 6'd0 && out_leg == 6'd0, "R1 outputs low after reset", {out_ext, out_leg}, 0);
    rd_addr = 1'b0; #1;
    check(rd_ext == 32'd0, "R1 word0 zero", rd_ext, 0);
    rd_addr = 1'b1; #1;
    check(rd_ext == 32'd0, "R1 word1 zero", rd_ext, 0);
    @(negedge clk);
    wr(1'b1, 32'hDEAD_BEEF);
    rd_addr = 1'b1; #1;
    check(rd_ext == 32'hDEAD_BEEF, "R2 word1 readback", rd_ext, 32'hDEAD_BEEF);
    check(rd_leg == 32'hDEAD_BEEF, "R2 legacy readback", rd_leg, 32'hDEAD_BEEF);
    @(negedge clk);
    clear_cfg();
  endtask

  task automatic t_even_ratio();
    int h, r;
    src_tick = 3'b001;
    wr(1'b0, 32'h0000_0009);          // gen0: N=2, mux=1, scale clear -> ratio 6
    measure(1'b0, 0, 12, h, r);
    check(h == 6, "R6 R7 ratio 6 high count", h, 6);
    check(r == 2, "R6 ratio 6 period count", r, 2);
    check(out_leg[0] == 1'b0, "R4 legacy enable bit clear keeps output low", out_leg[0], 0);
    clear_cfg();
  endtask

  task automatic t_odd_ratio();
    int h, r;
    src_tick = 3'b010;
    wr(1'b0, 32'h4000_0000);          // scale bit set
    wr(1'b1, 32'h0000_4800);          // gen4 (R3 field at bit 10): N=4, mux=2 -> ratio 5
    measure(1'b0, 4, 10, h, r);
    check(h == 4, "R7 R3 odd ratio 5 high count", h, 4);
    check(r == 2, "R6 scaled ratio 5 period count", r, 2);
    clear_cfg();
  endtask

  task automatic t_ratio_one();
    wr(1'b0, 32'h4030_0000);          // scale, gen2 N=0 mux=3
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      src_tick = {i[0], 2'b00};
      #1;
      check(out_ext[2] == i[0], "R8 ratio one follows tick", out_ext[2], i[0]);
      @(negedge clk);
    end
    clear_cfg();
  endtask

  task automatic t_select_disable_resume();
    int h, r;
    src_tick = 3'b001;                // wrong source for mux=2
    wr(1'b0, 32'h0000_0002);          // gen0: N=0, mux=2 -> ratio 2 on src_tick[1]
    measure(1'b0, 0, 6, h, r);
    check(h == 6 && r == 1, "R12 R5 unselected ticks leave output frozen", h, 6);
    src_tick = 3'b010;
    measure(1'b0, 0, 6, h, r);
    check(h == 3, "R5 selected source divides by 2", h, 3);
    wr(1'b0, 32'h0000_0000);
    rd_addr = 1'b0; #1;
    check(out_ext[0] == 1'b0, "R9 output low once field is off", out_ext[0], 0);
    check(rd_ext == 32'd0, "R2 readback after disable", rd_ext, 0);
    @(negedge clk);
    gen_resume = 6'b000001;
    @(negedge clk);
    gen_resume = '0;
    #1;
    check(rd_ext[1:0] == 2'd2, "R11 resume restores last mux", rd_ext[1:0], 2);
    check(rd_leg[1:0] == 2'b10, "R11 legacy resume sets enable", rd_leg[1:0], 2);
    measure(1'b0, 0, 6, h, r);
    check(h == 3, "R9 R11 resumed generator divides again", h, 3);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0000_0000; gen_resume = 6'b000010;
    @(negedge clk);
    wr_en = 1'b0; gen_resume = '0; #1;
    check(rd_ext == 32'd0, "R11 write wins over resume", rd_ext, 0);
    clear_cfg();
  endtask

  task automatic t_boundary();
    int guard;
    logic [9:0] seq;
    src_tick = 3'b001;
    wr(1'b0, 32'h0000_000D);          // gen0: N=3, mux=1 -> ratio 8
    guard = 0;
    while (!out_ext[0] && guard < 40) begin @(negedge clk); guard++; end
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0000_0001;  // N=0 -> ratio 2
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 9; i >= 0; i--) begin
      seq[i] = out_ext[0];
      @(negedge clk);
    end
    check(seq == 10'b1110000101, "R10 ratio change waits for period end", seq, 10'b1110000101);
    clear_cfg();
  endtask

  task automatic t_legacy();
    int h, r;
    src_tick = 3'b010;
    wr(1'b0, 32'h4000_0000);          // scale bit, ignored by legacy
    wr(1'b1, 32'h0000_0007);          // gen3: N=1, enable, source 1 -> ratio 4
    measure(1'b1, 3, 8, h, r);
    check(h == 4 && r == 2, "R4 legacy ratio 4 ignores scale", h, 4);
    clear_cfg();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_readback();
    t_even_ratio();
    t_odd_ratio();
    t_ratio_one();
    t_select_disable_resume();
    t_boundary();
    t_legacy();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule